// File: doc/BRIEF.md
# Selectable-Interval Watchdog Timer

This block guards against software that has lost control. Once software arms it, it counts cycles of a count clock taken from the main clock. If software does not restart it within the chosen interval, it raises a request. The request is either a system reset or a non-maskable interrupt, and software chooses which.

Software uses a single write port. Each write carries five things: a watchdog-enable bit, a run bit, an action bit and a 3-bit interval code, plus the write strobe itself. A write with the run bit set both starts the timer and clears it. The count clock runs at the main clock rate, or at half that rate, as set by the `full_rate` input.

A free-running prescaler is shared by all interval codes. It supplies a tick at a power-of-two period, and a small counter counts a fixed number of those ticks. A restart clears only that small counter and leaves the prescaler phase alone. For this reason a timeout can come up to one tick period earlier than nominal. Counting stops while the system is stopped or while it runs from the subsystem clock. Counting is not affected by halt.

Top module: `wdt_runaway`

## Requirements
- R1: After reset, neither `rst_req` nor `nmi_req` is asserted. No request is ever raised until a write with the run bit set has armed the timer.
- R2: Let B = BASE_LOG2 and W = CNT_W, and let the code be k. The nominal interval T is 2^(B+k) count-clock cycles for codes 0 to 6, and 2^(B+8) for code 7. The tick period P is T/2^W. At full rate (`full_rate`=1), the request appears d clocks after the arming write's clock edge, where T-P+1 <= d <= T.
- R3: At half rate (`full_rate`=0), one count-clock cycle is two clocks. The window of R2 becomes 2(T-P)+1 <= d <= 2T.
- R4: Each write with `cfg_run`=1 and `cfg_wdog`=1 clears the count. Rewrites that come more often than the interval prevent any request. After the last rewrite, the R2 window is measured from that rewrite.
- R5: When `cfg_act_rst`=1 at expiry, `rst_req` is raised; when it is 0, `nmi_req` is raised. Each request lasts exactly one clock, and the two are never high together.
- R6: After a reset request the timer is disarmed. No further request appears until the run bit is written again.
- R7: After an interrupt request the timer keeps counting. The next interrupt request comes exactly T clocks (full rate) or 2T clocks (half rate) after the previous one.
- R8: Holding `halt`=1 has no effect on the timing of R2.
- R9: While `stop`=1, both the prescaler and the counter hold. The R2 window is shifted later by the number of clocks that `stop` was held.
- R10: While `sub_clk`=1, counting is suspended in the same way as for R9.
- R11: A write with `cfg_run`=0 and `cfg_wdog`=1 updates the interval code and the action. It does not clear the count, so the new code applies to the ticks still to come.
- R12: A write with `cfg_wdog`=0 does not start the timer, and it disarms a running timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the fields below |
| cfg_run | input | 1 | Run bit: 1 starts or restarts the timer |
| cfg_wdog | input | 1 | Watchdog enable: 1 allows runaway detection |
| cfg_act_rst | input | 1 | Expiry action: 1 means reset request, 0 means interrupt request |
| cfg_ival | input | 3 | Interval code (see R2) |
| full_rate | input | 1 | 1 selects a full-rate count clock, 0 selects half rate |
| halt | input | 1 | Halt status (does not affect counting) |
| stop | input | 1 | Stop status: freezes counting |
| sub_clk | input | 1 | Subsystem-clock operation: freezes counting |
| rst_req | output | 1 | One-clock system reset request |
| nmi_req | output | 1 | One-clock non-maskable interrupt request |

## Verification
A wrong tap choice or a wrong counter limit makes the request appear outside the R2 window. This shows up at the first expiry, within a few thousand clocks. A prescaler that is cleared or not frozen when it should be shows as a gap between repeated interrupts that is not exactly T, or as a window that does not shift by the stop time. A wrong run-bit state shows as a request before arming, a missing request, or a second request after a reset expiry. Each of these appears within one interval.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Offset of the prescaler tap above the base tap for an interval code.
  // The top code skips one power of two.
  function automatic int unsigned tap_offset(input int unsigned code);
    return (code == 7) ? 8 : code;
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int E_MAX = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_en,
  input  logic           full_rate,
  output logic [E_MAX:0] tap
);
  logic             ph_q, ph_d;
  logic [E_MAX-1:0] pre_q, pre_d;
  logic             cen;

  // Count-clock enable: every clock, or every other clock at half rate.
  assign cen = run_en && (full_rate || ph_q);

  always_comb begin
    ph_d  = ph_q;
    pre_d = pre_q;
    if (run_en) ph_d  = ~ph_q;
    if (cen)    pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 1'b0;
      pre_q <= '0;
    end else begin
      ph_q  <= ph_d;
      pre_q <= pre_d;
    end
  end

  // tap[i] pulses once every 2^i count-clock cycles.
  assign tap[0] = cen;
  generate
    for (genvar i = 0; i < E_MAX; i++) begin : g_tap
      assign tap[i+1] = tap[i] & pre_q[i];
    end
  endgenerate

  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(pre_q));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_run,
  input  logic       cfg_wdog,
  input  logic       cfg_act_rst,
  input  logic [2:0] cfg_ival,
  input  logic       tick,
  output logic [2:0] ival_q,
  output logic       rst_req,
  output logic       nmi_req
);
  logic             run_q, run_d;
  logic             act_q, act_d;
  logic [2:0]       ival_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start, expire;

  always_comb begin
    start  = cfg_we && cfg_run && cfg_wdog;
    expire = run_q && tick && (&cnt_q) && !start;

    act_d  = cfg_we ? cfg_act_rst : act_q;
    ival_d = cfg_we ? cfg_ival : ival_q;

    run_d = run_q;
    if (cfg_we && !cfg_wdog) run_d = 1'b0;
    if (expire && act_q)     run_d = 1'b0;
    if (start)               run_d = 1'b1;

    cnt_d = cnt_q;
    if (start)      cnt_d = '0;
    else if (!run_d) cnt_d = '0;
    else if (tick)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      act_q   <= 1'b0;
      ival_q  <= '0;
      cnt_q   <= '0;
      rst_req <= 1'b0;
      nmi_req <= 1'b0;
    end else begin
      run_q   <= run_d;
      act_q   <= act_d;
      ival_q  <= ival_d;
      cnt_q   <= cnt_d;
      rst_req <= expire && act_q;
      nmi_req <= expire && !act_q;
    end
  end

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !(rst_req || nmi_req));
  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == '0) && run_q);
  p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_req, nmi_req}));
  p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || nmi_req) |=> !(rst_req || nmi_req));
  p_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !run_q);
  p_wdog_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_wdog) |=> !run_q);
endmodule

// File: rtl/wdt_runaway.sv
module wdt_runaway #(
  parameter int BASE_LOG2 = 11,
  parameter int CNT_W     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_run,
  input  logic       cfg_wdog,
  input  logic       cfg_act_rst,
  input  logic [2:0] cfg_ival,
  input  logic       full_rate,
  input  logic       halt,
  input  logic       stop,
  input  logic       sub_clk,
  output logic       rst_req,
  output logic       nmi_req
);
  import wdt_pkg::*;

  localparam int E0    = BASE_LOG2 - CNT_W;
  localparam int E_MAX = E0 + 8;

  logic [1:0]       rst_pipe;
  logic             rst_s;
  logic             cnt_en;
  logic [E_MAX:0]   tap;
  logic [7:0]       cand;
  logic [2:0]       ival_q;
  logic             tick;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  // Main clock stands still in stop and while the subsystem clock drives the CPU.
  assign cnt_en = !stop && !sub_clk;

  wdt_prescaler #(.E_MAX(E_MAX)) u_pre (
    .clk       (clk),
    .rst_n     (rst_s),
    .run_en    (cnt_en),
    .full_rate (full_rate),
    .tap       (tap)
  );

  generate
    for (genvar k = 0; k < 8; k++) begin : g_cand
      assign cand[k] = tap[E0 + tap_offset(k)];
    end
  endgenerate
  assign tick = cand[ival_q];

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_s),
    .cfg_we      (cfg_we),
    .cfg_run     (cfg_run),
    .cfg_wdog    (cfg_wdog),
    .cfg_act_rst (cfg_act_rst),
    .cfg_ival    (cfg_ival),
    .tick        (tick),
    .ival_q      (ival_q),
    .rst_req     (rst_req),
    .nmi_req     (nmi_req)
  );

  p_halt_runs_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (halt && !stop && !sub_clk) |-> cnt_en);
  p_frozen_tick_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (stop || sub_clk) |-> !tick);
endmodule

// File: tb/wdt_runaway_test.sv
module wdt_runaway_test;
  localparam int B = 4;
  localparam int W = 2;

  logic clk, rst_n;
  logic cfg_we, cfg_run, cfg_wdog, cfg_act_rst;
  logic [2:0] cfg_ival;
  logic full_rate, halt, stop, sub_clk;
  logic rst_req, nmi_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  wdt_runaway #(.BASE_LOG2(B), .CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_run(cfg_run),
    .cfg_wdog(cfg_wdog), .cfg_act_rst(cfg_act_rst), .cfg_ival(cfg_ival),
    .full_rate(full_rate), .halt(halt), .stop(stop), .sub_clk(sub_clk),
    .rst_req(rst_req), .nmi_req(nmi_req)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic int nominal(input int k);
    return 1 << (B + ((k == 7) ? 8 : k));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_win(input string req, input int d, input int lo, input int hi);
    checks++;
    if (d < lo || d > hi) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, d, lo, hi);
    end
  endtask

  task automatic wr(input bit run, input bit wd, input bit act, input int k);
    cfg_we = 1; cfg_run = run; cfg_wdog = wd; cfg_act_rst = act; cfg_ival = 3'(k);
    @(negedge clk);
    cfg_we = 0; cfg_run = 0;
  endtask

  // Returns edges after the reference edge until a request is seen (-1 if none).
  // A freeze of flen clocks on stop (fsel=0) or sub_clk (fsel=1) starts at fstart.
  task automatic wait_req(input int maxd, input int fstart, input int flen, input bit fsel,
                          output int d, output bit was_rst);
    d = -1; was_rst = 0;
    for (int i = 1; i <= maxd; i++) begin
      if (flen > 0 && i == fstart + 1) begin if (fsel) sub_clk = 1; else stop = 1; end
      if (flen > 0 && i == fstart + flen + 1) begin sub_clk = 0; stop = 0; end
      @(negedge clk);
      if (rst_req || nmi_req) begin
        d = i; was_rst = rst_req;
        check(!(rst_req && nmi_req), "R5 both", 1, 0);
        break;
      end
    end
    sub_clk = 0; stop = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int d, T, P, lo, hi;
    bit wr_rst;
    cfg_we = 0; cfg_run = 0; cfg_wdog = 0; cfg_act_rst = 0; cfg_ival = 0;
    full_rate = 1; halt = 0; stop = 0; sub_clk = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state and no request before arming
    check(!rst_req && !nmi_req, "R1 reset", int'(rst_req | nmi_req), 0);
    wait_req(300, 0, 0, 0, d, wr_rst);
    check(d == -1, "R1 unarmed", d, -1);

    // R12: run with watchdog disabled does not start
    wr(1, 0, 1, 0);
    wait_req(200, 0, 0, 0, d, wr_rst);
    check(d == -1, "R12 no start", d, -1);

    // R2 / R3 / R5: sweep all codes at both rates with reset action
    for (int rate = 1; rate >= 0; rate--) begin
      full_rate = rate[0];
      for (int k = 0; k < 8; k++) begin
        int r;
        r = rate ? 1 : 2;
        T = nominal(k); P = T >> W;
        lo = r * (T - P) + 1; hi = r * T;
        wr(1, 1, 1, k);
        wait_req(hi + 8, 0, 0, 0, d, wr_rst);
        if (rate) check_win("R2 interval", d, lo, hi);
        else      check_win("R3 half rate", d, lo, hi);
        check(wr_rst, "R5 reset action", int'(wr_rst), 1);
        @(negedge clk);
        check(!rst_req && !nmi_req, "R5 one clock", int'(rst_req | nmi_req), 0);
        if (k == 0) begin
          wait_req(3 * r * T, 0, 0, 0, d, wr_rst);
          check(d == -1, "R6 disarmed", d, -1);
        end
      end
    end

    // R7: interrupt action keeps counting, gaps exactly T
    full_rate = 1;
    T = nominal(1); P = T >> W;
    wr(1, 1, 0, 1);
    wait_req(T + 8, 0, 0, 0, d, wr_rst);
    check_win("R7 first", d, T - P + 1, T);
    check(!wr_rst, "R5 nmi action", int'(wr_rst), 0);
    for (int n = 0; n < 2; n++) begin
      wait_req(T + 8, 0, 0, 0, d, wr_rst);
      check(d == T && !wr_rst, "R7 gap full", d, T);
    end
    full_rate = 0;
    T = nominal(0);
    wait_req(2 * nominal(1) + 8, 0, 0, 0, d, wr_rst);
    wr(1, 1, 0, 0);
    wait_req(2 * T + 8, 0, 0, 0, d, wr_rst);
    wait_req(2 * T + 8, 0, 0, 0, d, wr_rst);
    check(d == 2 * T && !wr_rst, "R7 gap half", d, 2 * T);
    wr(0, 0, 0, 0);
    wait_req(200, 0, 0, 0, d, wr_rst);
    check(d == -1, "R12 disarm", d, -1);

    // R4: repeated restarts hold off expiry
    full_rate = 1;
    T = nominal(2); P = T >> W;
    wr(1, 1, 1, 2);
    for (int n = 0; n < 5; n++) begin
      wait_req(40, 0, 0, 0, d, wr_rst);
      check(d == -1, "R4 held off", d, -1);
      wr(1, 1, 1, 2);
    end
    wait_req(T + 8, 0, 0, 0, d, wr_rst);
    check_win("R4 after restart", d, T - P + 1, T);

    // R8: halt has no effect
    halt = 1;
    T = nominal(1); P = T >> W;
    wr(1, 1, 1, 1);
    wait_req(T + 8, 0, 0, 0, d, wr_rst);
    check_win("R8 halt", d, T - P + 1, T);
    halt = 0;

    // R9: stop freezes for 50 clocks
    wr(1, 1, 1, 1);
    wait_req(T + 60, 5, 50, 0, d, wr_rst);
    check_win("R9 stop", d, T - P + 1 + 50, T + 50);

    // R10: subsystem clock freezes for 37 clocks, half rate
    full_rate = 0;
    T = nominal(0); P = T >> W;
    wr(1, 1, 1, 0);
    wait_req(2 * T + 50, 3, 37, 1, d, wr_rst);
    check_win("R10 sub clock", d, 2 * (T - P) + 1 + 37, 2 * T + 37);

    // R11: select change without run keeps the count
    full_rate = 1;
    wr(1, 1, 1, 0);
    wait_req(6, 0, 0, 0, d, wr_rst);
    check(d == -1, "R11 early", d, -1);
    wr(0, 1, 1, 1);
    wait_req(40, 0, 0, 0, d, wr_rst);
    check_win("R11 no clear", d, 1, 24);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule